// File: doc/BRIEF.md
# Block-Floating Mantissa Expander

This block follows a quadrature mixer in a receive channel whose front-end amplifier changes gain in 6 dB steps. The mixer hands over each I and Q sample as a signed 15-bit mantissa. The gain loop supplies a 3-bit unsigned exponent that records how far the amplifier gain was stepped down. The expander shifts both mantissas left by that exponent, one bit per 6 dB step. It produces 22-bit signed fixed-point samples, so the channel output tracks the amplifier input linearly and gain steps do not appear downstream.

The exponent travels a shorter path than the data, which has to pass through the mixer pipeline first. For this reason the exponent goes through a delay line whose depth, from 0 to 7 cycles, is chosen at run time. Each mantissa is then scaled by the exponent that belongs to it. An inhibit control overrides the delayed exponent with its maximum value of 7. Both lanes share one exponent per sample. Results are registered, and the output-valid strobe follows the input-valid strobe by one cycle.

Top module: `bfm_expander`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_i`/`out_q` are 0.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: For a sample accepted with `in_valid` high, the output one clock later equals the mantissa sign-extended to 22 bits and multiplied by 2^e, with zeros in the low e bits. This holds for every 15-bit input from -16384 to 16383 and every e from 0 to 7, with no saturation or rounding.
- R4: The I and Q lanes of one sample are scaled by the same exponent value.
- R5: When `exp_inhibit` is 1 at the sample's input cycle, e is 7 regardless of `exp_in`.
- R6: With `exp_lag` = L (0 to 7), the exponent applied to a sample is the `exp_in` value presented L clocks before that sample's cycle, with 0 for cycles inside reset. L = 0 uses the current `exp_in`.
- R7: When `in_valid` is low, `out_i` and `out_q` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the mantissas of this cycle |
| mant_i | input | 15 | Signed in-phase mantissa |
| mant_q | input | 15 | Signed quadrature mantissa |
| exp_in | input | 3 | Unsigned exponent from the gain loop |
| exp_inhibit | input | 1 | Forces the exponent to 7 |
| exp_lag | input | 3 | Exponent delay in clocks, 0 to 7 |
| out_valid | output | 1 | Registered copy of in_valid |
| out_i | output | 22 | Expanded signed in-phase sample |
| out_q | output | 22 | Expanded signed quadrature sample |

## Verification
The first pattern drives full-scale positive, full-scale negative, zero and minus-one mantissas across all eight exponents. It separates a correct sign extension from zero fill or bit truncation at the top of the 22-bit range. The second pattern sends a random stream with the exponent changing every cycle and I and Q set to different values. Under that stream, an exponent delay that is off by one cycle, or a lane that takes the wrong exponent, gives a wrong product. The third and fourth patterns exercise the inhibit bit and sweep every lag setting, with gaps in the valid strobe to show that the outputs hold.

// File: rtl/bfm_expander_pkg.sv
package bfm_expander_pkg;
  localparam int MANT_W  = 15;
  localparam int EXP_W   = 3;
  localparam int MAX_LAG = 7;
  localparam int LAG_W   = $clog2(MAX_LAG + 1);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int OUT_W   = MANT_W + MAX_EXP;
  localparam int LANES   = 2;
endpackage

// File: rtl/bfm_exp_delay.sv
module bfm_exp_delay #(
  parameter int EXP_W   = 3,
  parameter int MAX_LAG = 7,
  parameter int LAG_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [LAG_W-1:0] lag,
  output logic [EXP_W-1:0] exp_out
);
  logic [EXP_W-1:0] taps [MAX_LAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < MAX_LAG; k++) taps[k] <= '0;
    end else begin
      taps[0] <= exp_in;
      for (int k = 1; k < MAX_LAG; k++) taps[k] <= taps[k-1];
    end
  end

  always_comb begin
    if (lag == '0)
      exp_out = exp_in;
    else if (int'(lag) > MAX_LAG)
      exp_out = taps[MAX_LAG-1];
    else
      exp_out = taps[int'(lag) - 1];
  end

  // R6
  first_tap_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> taps[0] == $past(exp_in));
endmodule

// File: rtl/bfm_mant_shift.sv
module bfm_mant_shift #(
  parameter int MANT_W = 15,
  parameter int EXP_W  = 3,
  parameter int OUT_W  = 22
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  shamt,
  output logic [OUT_W-1:0]  expanded
);
  logic [OUT_W-1:0] ext;

  always_comb begin
    ext      = {{(OUT_W-MANT_W){mant[MANT_W-1]}}, mant};
    expanded = ext << shamt;
  end
endmodule

// File: rtl/bfm_expander.sv
module bfm_expander
  import bfm_expander_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [MANT_W-1:0] mant_q,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic              exp_inhibit,
  input  logic [LAG_W-1:0]  exp_lag,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_i,
  output logic [OUT_W-1:0]  out_q
);
  logic [EXP_W-1:0]  exp_aligned;
  logic [EXP_W-1:0]  exp_eff;
  logic [MANT_W-1:0] lane_in  [LANES];
  logic [OUT_W-1:0]  lane_out [LANES];

  bfm_exp_delay #(.EXP_W(EXP_W), .MAX_LAG(MAX_LAG), .LAG_W(LAG_W)) u_delay (
    .clk(clk), .rst(rst), .exp_in(exp_in), .lag(exp_lag), .exp_out(exp_aligned)
  );

  assign exp_eff    = exp_inhibit ? EXP_W'(MAX_EXP) : exp_aligned;
  assign lane_in[0] = mant_i;
  assign lane_in[1] = mant_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bfm_mant_shift #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) u_shift (
      .mant(lane_in[g]), .shamt(exp_eff), .expanded(lane_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= lane_out[0];
        out_q <= lane_out[1];
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(out_i) && $stable(out_q)));

  // R5
  inhibit_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && exp_inhibit)) |->
      (out_i[MAX_EXP-1:0] == '0 && out_q[MAX_EXP-1:0] == '0));

  // R3
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |->
      (out_i[OUT_W-1] == $past(mant_i[MANT_W-1]) &&
       out_q[OUT_W-1] == $past(mant_q[MANT_W-1])));
endmodule

// File: tb/bfm_expander_tb.sv
module bfm_expander_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [14:0] mant_i = '0;
  logic [14:0] mant_q = '0;
  logic [2:0]  exp_in = '0;
  logic        exp_inhibit = 1'b0;
  logic [2:0]  exp_lag = '0;
  logic        out_valid;
  logic [21:0] out_i, out_q;

  int tests = 0;
  int fails = 0;
  logic [21:0] exp_qi [$];
  logic [21:0] exp_qq [$];
  logic [2:0]  past_e [8];
  logic [21:0] prev_i = '0;
  logic [21:0] prev_q = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bfm_expander u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mant_i(mant_i), .mant_q(mant_q),
    .exp_in(exp_in), .exp_inhibit(exp_inhibit), .exp_lag(exp_lag),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic logic [21:0] scale(input logic [14:0] m, input int e);
    longint v;
    v = longint'($signed(m)) * (longint'(1) << e);
    return v[21:0];
  endfunction

  task automatic check(input string req, input logic [21:0] act, input logic [21:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // R1 R2 R3 R4 R5 R6: one sample per clock, expected value from bench history
  task automatic drive(input logic v, input logic [14:0] mi, input logic [14:0] mq,
                       input logic [2:0] e, input logic inh, input logic [2:0] lag);
    int ee;
    @(negedge clk);
    in_valid = v; mant_i = mi; mant_q = mq; exp_in = e; exp_inhibit = inh; exp_lag = lag;
    ee = inh ? 7 : ((lag == 0) ? int'(e) : int'(past_e[lag-1]));
    if (v) begin
      exp_qi.push_back(scale(mi, ee));
      exp_qq.push_back(scale(mq, ee));
    end
    @(posedge clk);
    for (int k = 7; k > 0; k--) past_e[k] = past_e[k-1];
    past_e[0] = rst ? 3'd0 : e;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (out_valid) begin
          if (exp_qi.size() == 0) begin
            tests++; fails++;
            $display("FAIL R2 actual=unexpected valid expected=no valid");
          end else begin
            check("R3/R4/R5/R6 lane I", out_i, exp_qi.pop_front());
            check("R3/R4/R5/R6 lane Q", out_q, exp_qq.pop_front());
          end
        end else begin
          check("R7 hold I", out_i, prev_i);
          check("R7 hold Q", out_q, prev_q);
        end
        prev_i = out_i;
        prev_q = out_q;
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [14:0] edge_vals [4];
    edge_vals[0] = 15'h3FFF; edge_vals[1] = 15'h4000;
    edge_vals[2] = 15'h0000; edge_vals[3] = 15'h7FFF;
    for (int k = 0; k < 8; k++) past_e[k] = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 valid in reset", {21'd0, out_valid}, 22'd0);
    check("R1 I in reset", out_i, 22'd0);
    check("R1 Q in reset", out_q, 22'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {21'd0, out_valid}, 22'd0);
    check("R1 I after reset", out_i, 22'd0);
    // R3 extremes at every exponent, lag 0
    for (int e = 0; e < 8; e++)
      for (int a = 0; a < 4; a++)
        drive(1'b1, edge_vals[a], edge_vals[3-a], 3'(e), 1'b0, 3'd0);
    // R7 idle gap, inputs changing
    for (int k = 0; k < 4; k++) drive(1'b0, 15'(k * 911), 15'h1234, 3'(k), 1'b0, 3'd0);
    // R5 inhibit ignores exp_in
    for (int k = 0; k < 8; k++) drive(1'b1, edge_vals[k % 4], 15'(k * 77), 3'(k), 1'b1, 3'd0);
    // R6 every lag with changing exponents, R4 differing lanes, random valid gaps
    for (int lag = 0; lag < 8; lag++)
      for (int n = 0; n < 40; n++)
        drive(($urandom % 4) != 0, 15'($urandom), 15'($urandom), 3'($urandom),
              ($urandom % 8) == 0, 3'(lag));
    drive(1'b0, '0, '0, '0, 1'b0, 3'd0);
    drive(1'b0, '0, '0, '0, 1'b0, 3'd0);
    if (exp_qi.size() != 0) begin
      tests++; fails++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_qi.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule